// File: doc/BRIEF.md
# Sync Clock Divider with Alignment

This block divides the system clock by four (by a power of two in general) to make a slow sync clock. Several synthesizer devices use that clock as their shared timing reference for register updates. The sync clock comes straight from the most significant bit of a free-running counter, so it has an even duty cycle.

Software can move the phase of the divider one system clock at a time. It does this by setting a manual-step bit. The block acts on the write once and then clears the bit by itself. When the automatic-alignment enable is high, a rising edge on the external sync input reloads the counter. The sync clock's rising edge then follows that input edge at a fixed latency, so every device fed by the same sync input ends up with the same divider phase.

Top module: `syncclk_div`

## Requirements
- R1: With no step and no alignment, the sync clock rises once every 2^DIV_W system clocks (every 4 by default).
- R2: The sync clock is high for 2^(DIV_W-1) system clocks and low for the same number (two and two by default). It is the most significant bit of the divider counter, which counts up from zero.
- R3: A manual step skips one count. The next sync clock rising edge comes one system clock early (3 clocks after the previous rise by default), and the spacing then returns to the full period.
- R4: The self-clearing step bit, `step_flag_o`, reads 1 for exactly one cycle. That cycle follows the first clock edge at which `man_step_i` is sampled high after being sampled low. The bit then returns to 0.
- R5: Holding `man_step_i` high for many cycles makes only one advance. Each further advance needs the input to go low and then high again.
- R6: With `auto_en_i` high, suppose a rising edge of `sync_in_i` is first sampled at clock edge e0. The counter is then loaded with 2^(DIV_W-1)-1 at edge e0+SYNC_STAGES. The sync clock is low after that edge and rises at the next edge (e0+3 by default).
- R7: With `auto_en_i` low, edges on `sync_in_i` have no effect on the sync clock phase.
- R8: Only a rising edge of the synchronised `sync_in_i` realigns the counter. A sync input held high leaves the divider free-running after the single realignment.
- R9: If an alignment load and a pending manual step fall in the same cycle, the load wins and the step is dropped.
- R10: During reset `sclk_o` and `step_flag_o` are 0 and the counter is 0. After reset is released, the first sync clock rise occurs at the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_in_i | input | 1 | External alignment input, asynchronous to clk_i |
| auto_en_i | input | 1 | Enables automatic alignment to sync_in_i |
| man_step_i | input | 1 | Manual-step bit written by software; acted on at its rising edge |
| sclk_o | output | 1 | Sync clock, system clock divided by 2^DIV_W |
| step_flag_o | output | 1 | Readback of the self-clearing step bit |

## Verification
The free-running divider is sampled over whole periods. These samples show whether the output has the right period and the right two-high, two-low duty cycle. Single manual pulses and a long held pulse separate a correct one-shot advance from one that repeats or is lost. Alignment is tried from four different starting phases, and the output must land on the same cycle each time, which shows that the load value and latency are fixed. Disabled alignment, a sync input held high, and a manual step that coincides with the load cover the cases where the input must be ignored or where one action must take priority over the other.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;
   // action applied to the divider counter in a given cycle
   typedef enum logic [1:0] {
      ACT_RUN   = 2'd0,
      ACT_SKIP  = 2'd1,
      ACT_ALIGN = 2'd2
   } div_act_e;
endpackage

// File: rtl/syncdiv_sync.sv
// Multi-stage synchroniser with rising-edge detect on the synchronised level.
module syncdiv_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[0] <= 1'b0;
      else         sh_q[0] <= async_i;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sh_q[i] <= 1'b0;
         else         sh_q[i] <= sh_q[i-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/syncdiv_step.sv
// Turns a software-written level into a single-cycle, self-clearing step bit.
module syncdiv_step (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic flag_o
);
   logic prev_q;
   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= req_i;
         flag_q <= req_i & ~prev_q;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/syncdiv_count.sv
// Divider counter: count, skip one count, or load the alignment value.
module syncdiv_count
   import syncdiv_pkg::*;
#(
   parameter int unsigned DIV_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  div_act_e         act_i,
   output logic [DIV_W-1:0] cnt_o
);
   localparam logic [DIV_W-1:0] INC1 = DIV_W'(1);
   localparam logic [DIV_W-1:0] INC2 = DIV_W'(2);
   // one count before the half-way point: the MSB rises on the next edge
   localparam logic [DIV_W-1:0] LOAD = DIV_W'((1 << (DIV_W-1)) - 1);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         case (act_i)
            ACT_ALIGN: cnt_q <= LOAD;
            ACT_SKIP:  cnt_q <= cnt_q + INC2;
            default:   cnt_q <= cnt_q + INC1;
         endcase
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/syncclk_div.sv
module syncclk_div
   import syncdiv_pkg::*;
#(
   parameter int unsigned DIV_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_in_i,
   input  logic auto_en_i,
   input  logic man_step_i,
   output logic sclk_o,
   output logic step_flag_o
);
   if (DIV_W < 2) begin : g_bad_div
      $error("syncclk_div: DIV_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("syncclk_div: SYNC_STAGES must be at least 2");
   end

   logic             sync_rise;
   logic             step_flag;
   logic [DIV_W-1:0] div_cnt;
   div_act_e         div_act;

   syncdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (sync_in_i),
      .rise_o  (sync_rise)
   );

   syncdiv_step u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (man_step_i),
      .flag_o (step_flag)
   );

   // alignment has priority; a colliding step is dropped
   always_comb begin
      if (auto_en_i && sync_rise) div_act = ACT_ALIGN;
      else if (step_flag)         div_act = ACT_SKIP;
      else                        div_act = ACT_RUN;
   end

   syncdiv_count #(.DIV_W(DIV_W)) u_count (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (div_act),
      .cnt_o  (div_cnt)
   );

   assign sclk_o      = div_cnt[DIV_W-1];
   assign step_flag_o = step_flag;
endmodule

// File: rtl/syncclk_div_chk.sv
module syncclk_div_chk #(
   parameter int unsigned DIV_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             auto_en_i,
   input logic             rise_i,
   input logic             step_i,
   input logic             sclk_i,
   input logic [DIV_W-1:0] cnt_i
);
   localparam logic [DIV_W-1:0] LOAD = DIV_W'((1 << (DIV_W-1)) - 1);

   assert_free_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !(auto_en_i && rise_i)) |=> (cnt_i == DIV_W'($past(cnt_i) + 1)));

   assert_high_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(sclk_i) && !step_i && !(auto_en_i && rise_i)) |=> sclk_i);

   assert_skip_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !(auto_en_i && rise_i)) |=> (cnt_i == DIV_W'($past(cnt_i) + 2)));

   assert_self_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |=> !step_i);

   assert_align_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_en_i && rise_i) |=> (cnt_i == LOAD));   // covers R6 and R9

   assert_no_auto_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!auto_en_i && !step_i) |=> (cnt_i == DIV_W'($past(cnt_i) + 1)));
endmodule

bind syncclk_div syncclk_div_chk #(.DIV_W(DIV_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .auto_en_i (auto_en_i),
   .rise_i    (sync_rise),
   .step_i    (step_flag),
   .sclk_i    (sclk_o),
   .cnt_i     (div_cnt)
);

// File: tb/syncclk_div_bench.sv
module syncclk_div_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_in = 1'b0;
   logic auto_en = 1'b0;
   logic man_step = 1'b0;
   logic sclk;
   logic step_flag;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   syncclk_div u_syncclk_div (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sync_in_i   (sync_in),
      .auto_en_i   (auto_en),
      .man_step_i  (man_step),
      .sclk_o      (sclk),
      .step_flag_o (step_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // returns the cycle number of the next observed sync clock rise
   task automatic wait_rise(output int t);
      bit p;
      p = sclk;
      t = -1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (sclk && !p) begin
            t = cyc;
            break;
         end
         p = sclk;
      end
   endtask

   task automatic t_reset();
      int c;
      @(negedge clk);
      check(sclk == 1'b0, "R10 sclk in reset", sclk, 0);
      check(step_flag == 1'b0, "R10 flag in reset", step_flag, 0);
      rst_n = 1'b1;
      c = cyc;
      @(negedge clk);
      check(cyc == c + 1 && sclk == 1'b0, "R10 first edge low", sclk, 0);
      @(negedge clk);
      check(sclk == 1'b1, "R10 rise at second edge", sclk, 1);
   endtask

   task automatic t_free();
      int t0, t1;
      wait_rise(t0);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         check(sclk == ((k % 4) <= 1), "R2 duty pattern", sclk, ((k % 4) <= 1));
      end
      wait_rise(t0);
      wait_rise(t1);
      check(t1 - t0 == 4, "R1 period", t1 - t0, 4);
   endtask

   task automatic t_step();
      int t0, t1, t2;
      wait_rise(t0);
      man_step = 1'b1;
      @(negedge clk);
      check(step_flag == 1'b1, "R4 flag set", step_flag, 1);
      man_step = 1'b0;
      @(negedge clk);
      check(step_flag == 1'b0, "R4 flag cleared", step_flag, 0);
      wait_rise(t1);
      check(t1 - t0 == 3, "R3 early rise", t1 - t0, 3);
      wait_rise(t2);
      check(t2 - t1 == 4, "R3 period restored", t2 - t1, 4);
   endtask

   task automatic t_hold();
      int t0, nflag, nrise, first;
      bit p;
      wait_rise(t0);
      man_step = 1'b1;
      nflag = 0; nrise = 0; first = -1;
      p = sclk;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         if (step_flag) nflag++;
         if (sclk && !p) begin
            nrise++;
            if (first < 0) first = k;
         end
         p = sclk;
      end
      man_step = 1'b0;
      check(nflag == 1, "R5 one flag while held", nflag, 1);
      check(nrise == 3, "R5 rises while held", nrise, 3);
      check(first == 3, "R5 single advance", first, 3);
      tick(2);
   endtask

   task automatic t_align(input int offset);
      int c, t;
      auto_en = 1'b1;
      tick(4 + offset);
      sync_in = 1'b1;
      c = cyc;
      tick(3);
      check(sclk == 1'b0, "R6 low after load", sclk, 0);
      @(negedge clk);
      check(sclk == 1'b1, "R6 aligned rise", sclk, 1);
      wait_rise(t);
      check(t == c + 8, "R8 held sync no realign", t - c, 8);
      sync_in = 1'b0;
      tick(4);
   endtask

   task automatic t_noauto();
      int t0, t1, t2;
      auto_en = 1'b0;
      tick(4);
      wait_rise(t0);
      @(negedge clk);
      sync_in = 1'b1;
      wait_rise(t1);
      check(t1 - t0 == 4, "R7 ignored sync", t1 - t0, 4);
      wait_rise(t2);
      check(t2 - t1 == 4, "R7 cadence kept", t2 - t1, 4);
      sync_in = 1'b0;
      tick(4);
   endtask

   task automatic t_collide();
      int c, t;
      auto_en = 1'b1;
      tick(5);
      sync_in = 1'b1;
      c = cyc;
      @(negedge clk);
      man_step = 1'b1;
      @(negedge clk);
      man_step = 1'b0;
      @(negedge clk);
      check(sclk == 1'b0, "R9 load wins low", sclk, 0);
      @(negedge clk);
      check(sclk == 1'b1, "R9 load wins rise", sclk, 1);
      wait_rise(t);
      check(t == c + 8, "R9 step dropped", t - c, 8);
      sync_in = 1'b0;
      auto_en = 1'b0;
      tick(4);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_free();
      t_step();
      t_hold();
      for (int o = 0; o < 4; o++) t_align(o);
      t_noauto();
      t_collide();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule